// File: doc/BRIEF.md
# Read-Address Key Detector for Nonvolatile Store and Recall

This block watches the stream of completed memory accesses to an SRAM that has a nonvolatile shadow. Software asks for a nonvolatile operation without any dedicated pin. It reads six locations in a fixed order. The first five addresses are common to both commands. The sixth address decides which command is meant: 0x0F0F asks for a store and 0x0F0E asks for a recall.

When the key completes, the block sends a single-cycle request pulse to the nonvolatile controller. It also raises a single-cycle flag that tells the data path to float its outputs for that access. The five earlier reads are ordinary reads, so the flag stays low for them.

The detector only tracks the order of the accesses. Any write or wrong address drops the progress. Deselected accesses and idle cycles are ignored. While the controller is busy, the detector is held at its idle state.

Top module: `nvu_seq_unlock`

## Requirements
- R1: Six consecutive selected reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F raise `store_req` for exactly the cycle after the clock edge that samples the sixth access.
- R2: The same first five reads followed by a read at 0x0F0E raise `recall_req` for exactly the cycle after the sixth access. `store_req` and `recall_req` are never high together.
- R3: A selected access with `wr_en`=1 (write) at any step abandons the key, so finishing the remaining reads afterwards produces no request.
- R4: An access strobe with `chip_sel`=0 is not a step. It neither advances nor resets the progress.
- R5: `data_hiz` is high for exactly the cycle after a completed sixth access and is low after each of the first five reads.
- R6: A selected read at a wrong address resets the progress. If that address is 0x0000, it counts as step one of a new attempt.
- R7: After a request pulse the progress is idle, so a lone repeat of the sixth address produces no further request.
- R8: While `ctrl_busy` is high, every access is discarded, the progress is held idle and no request is issued.
- R9: After `rst` all outputs are low, and a key begun before the reset cannot be completed after it.
- R10: Cycles with `acc_valid`=0 leave the progress untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One completed memory access this cycle |
| chip_sel | input | 1 | Chip selected during that access (1 = selected) |
| wr_en | input | 1 | Access was a write (1) or a read (0) |
| addr | input | 13 | Access address |
| ctrl_busy | input | 1 | Nonvolatile controller is busy |
| store_req | output | 1 | One-cycle store request |
| recall_req | output | 1 | One-cycle recall request |
| data_hiz | output | 1 | One-cycle request to float the data outputs |

## Verification
A step counter that is left one position wrong changes the outcome of every later key. It can make a valid six-read key fail to produce a pulse, or it can produce a pulse after only five reads. The bench shows this at the cycle following the sixth access. A counter that is not cleared after a pulse, after a write or during busy shows up as a spurious pulse when a lone sixth address follows. A mix-up between the two final addresses appears as the wrong request line on that same cycle.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
  localparam int ADDR_W  = 13;
  localparam int KEY_LEN = 6;
  localparam int STEP_W  = $clog2(KEY_LEN);
  localparam int LAST    = KEY_LEN - 1;

  // Shared prefix of the key; index LAST gives the store terminator.
  function automatic logic [ADDR_W-1:0] key_addr(input int idx);
    case (idx)
      0:       key_addr = 13'h0000;
      1:       key_addr = 13'h1555;
      2:       key_addr = 13'h0AAA;
      3:       key_addr = 13'h1FFF;
      4:       key_addr = 13'h10F0;
      default: key_addr = 13'h0F0F;
    endcase
  endfunction

  localparam logic [ADDR_W-1:0] STORE_END  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] RECALL_END = 13'h0F0E;
endpackage

// File: rtl/nvu_key_match.sv
module nvu_key_match
  import nvu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int KL = KEY_LEN,
  parameter int SW = STEP_W
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] step,
  output logic          prefix_hit,
  output logic          store_hit,
  output logic          recall_hit,
  output logic          is_start
);
  logic [KL-2:0] hit;

  genvar g;
  generate
    for (g = 0; g < KL - 1; g++) begin : g_cmp
      assign hit[g] = (addr == key_addr(g));
    end
  endgenerate

  always_comb begin
    prefix_hit = 1'b0;
    for (int i = 0; i < KL - 1; i++)
      if (step == SW'(i)) prefix_hit = hit[i];
  end

  assign store_hit  = (step == SW'(KL - 1)) && (addr == STORE_END);
  assign recall_hit = (step == SW'(KL - 1)) && (addr == RECALL_END);
  assign is_start   = hit[0];
endmodule

// File: rtl/nvu_step_ctr.sv
module nvu_step_ctr
  import nvu_pkg::*;
#(
  parameter int KL = KEY_LEN,
  parameter int SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  input  logic          miss,
  input  logic          miss_start,
  output logic [SW-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst || clear)  step <= '0;
    else if (advance)  step <= step + SW'(1);
    else if (miss)     step <= miss_start ? SW'(1) : '0;
  end

  // R6: a miss never leaves progress beyond step one
  p_miss_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (miss && !clear && !advance) |=> (step <= SW'(1)));

  p_step_range_r1: assert property (@(posedge clk) disable iff (rst)
    step <= SW'(KL - 1));

  // R8/R3: clear forces idle
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (step == '0));
endmodule

// File: rtl/nvu_seq_unlock.sv
module nvu_seq_unlock
  import nvu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int KL = KEY_LEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          chip_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic          ctrl_busy,
  output logic          store_req,
  output logic          recall_req,
  output logic          data_hiz
);
  localparam int SW = $clog2(KL);

  logic [SW-1:0] step;
  logic prefix_hit, store_hit, recall_hit, is_start;
  logic access, take, at_last, done_s, done_r, advance, miss, clear;

  nvu_key_match #(.AW(AW), .KL(KL), .SW(SW)) u_match (
    .addr(addr), .step(step), .prefix_hit(prefix_hit),
    .store_hit(store_hit), .recall_hit(recall_hit), .is_start(is_start)
  );

  assign access  = acc_valid && chip_sel;
  assign take    = access && !wr_en && !ctrl_busy;
  assign at_last = (step == SW'(KL - 1));
  assign done_s  = take && store_hit;
  assign done_r  = take && recall_hit;
  assign advance = take && !at_last && prefix_hit;
  assign miss    = take && !advance && !done_s && !done_r;
  assign clear   = ctrl_busy || (access && wr_en) || done_s || done_r;

  nvu_step_ctr #(.KL(KL), .SW(SW)) u_step (
    .clk(clk), .rst(rst), .clear(clear), .advance(advance),
    .miss(miss), .miss_start(is_start), .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      data_hiz   <= 1'b0;
    end else begin
      store_req  <= done_s;
      recall_req <= done_r;
      data_hiz   <= take && at_last && (store_hit || recall_hit);
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req}));

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_busy |=> (!store_req && !recall_req));

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && chip_sel && wr_en) |=> (!store_req && !recall_req));

  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !chip_sel) |=> (!store_req && !recall_req && $stable(step)));

  p_single_r7: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |=> (!store_req && !recall_req));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !ctrl_busy) |=> $stable(step));
endmodule

// File: tb/nvu_seq_unlock_test.sv
module nvu_seq_unlock_test;
  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, chip_sel = 1'b0, wr_en = 1'b0, ctrl_busy = 1'b0;
  logic [12:0] addr = '0;
  logic store_req, recall_req, data_hiz;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  nvu_seq_unlock uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .chip_sel(chip_sel),
    .wr_en(wr_en), .addr(addr), .ctrl_busy(ctrl_busy),
    .store_req(store_req), .recall_req(recall_req), .data_hiz(data_hiz)
  );

  // {sel, wr, busy, addr[12:0], exp_store, exp_recall, req[3:0]}
  function automatic logic [21:0] mk(input logic s, input logic w, input logic b,
                                     input logic [12:0] a, input logic es,
                                     input logic er, input logic [3:0] rq);
    return {s, w, b, a, es, er, rq};
  endfunction

  localparam int NV = 49;
  localparam logic [21:0] VEC [NV] = '{
    // R1 store key
    mk(1,0,0,13'h0000,0,0,1), mk(1,0,0,13'h1555,0,0,1), mk(1,0,0,13'h0AAA,0,0,1),
    mk(1,0,0,13'h1FFF,0,0,1), mk(1,0,0,13'h10F0,0,0,1), mk(1,0,0,13'h0F0F,1,0,1),
    // R7 lone terminator after a pulse
    mk(1,0,0,13'h0F0F,0,0,7),
    // R2 recall key
    mk(1,0,0,13'h0000,0,0,2), mk(1,0,0,13'h1555,0,0,2), mk(1,0,0,13'h0AAA,0,0,2),
    mk(1,0,0,13'h1FFF,0,0,2), mk(1,0,0,13'h10F0,0,0,2), mk(1,0,0,13'h0F0E,0,1,2),
    // R3 write in the middle
    mk(1,0,0,13'h0000,0,0,3), mk(1,0,0,13'h1555,0,0,3), mk(1,1,0,13'h0AAA,0,0,3),
    mk(1,0,0,13'h0AAA,0,0,3), mk(1,0,0,13'h1FFF,0,0,3), mk(1,0,0,13'h10F0,0,0,3),
    mk(1,0,0,13'h0F0F,0,0,3),
    // R4 deselected access inside the key
    mk(1,0,0,13'h0000,0,0,4), mk(1,0,0,13'h1555,0,0,4), mk(0,1,0,13'h1234,0,0,4),
    mk(1,0,0,13'h0AAA,0,0,4), mk(1,0,0,13'h1FFF,0,0,4), mk(1,0,0,13'h10F0,0,0,4),
    mk(1,0,0,13'h0F0F,1,0,4),
    // R6 0x0000 mid-key restarts at step one
    mk(1,0,0,13'h0000,0,0,6), mk(1,0,0,13'h1555,0,0,6), mk(1,0,0,13'h0000,0,0,6),
    mk(1,0,0,13'h1555,0,0,6), mk(1,0,0,13'h0AAA,0,0,6), mk(1,0,0,13'h1FFF,0,0,6),
    mk(1,0,0,13'h10F0,0,0,6), mk(1,0,0,13'h0F0E,0,1,6),
    // R6 wrong address aborts; wrong terminator gives nothing
    mk(1,0,0,13'h0000,0,0,6), mk(1,0,0,13'h0AAB,0,0,6), mk(1,0,0,13'h1FFF,0,0,6),
    mk(1,0,0,13'h0000,0,0,6), mk(1,0,0,13'h1555,0,0,6), mk(1,0,0,13'h0AAA,0,0,6),
    mk(1,0,0,13'h1FFF,0,0,6), mk(1,0,0,13'h10F0,0,0,6), mk(1,0,0,13'h0F0D,0,0,6),
    // R8 busy during the key
    mk(1,0,0,13'h0000,0,0,8), mk(1,0,0,13'h1555,0,0,8), mk(1,0,1,13'h0AAA,0,0,8),
    mk(1,0,0,13'h1FFF,0,0,8), mk(1,0,0,13'h10F0,0,0,8)
  };

  task automatic chk(input string rq, input logic es, input logic er);
    checks++;
    if (store_req !== es || recall_req !== er || data_hiz !== (es | er)) begin
      failures++;
      $display("FAIL %s: store/recall/hiz=%b%b%b expected %b%b%b", rq,
               store_req, recall_req, data_hiz, es, er, es | er);
    end
  endtask

  task automatic acc(input logic s, input logic w, input logic b, input logic [12:0] a);
    @(negedge clk);
    acc_valid = 1'b1; chip_sel = s; wr_en = w; ctrl_busy = b; addr = a;
    @(posedge clk); #2;
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); acc_valid = 1'b0; ctrl_busy = 1'b0;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 chk("R9 reset", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:6]);
      chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][5], VEC[i][4]);
    end

    // R8: after busy released, a full store key works
    gap(1);
    acc(1,0,0,13'h0000); acc(1,0,0,13'h1555); acc(1,0,0,13'h0AAA);
    acc(1,0,0,13'h1FFF); acc(1,0,0,13'h10F0); acc(1,0,0,13'h0F0F);
    chk("R8 key after busy", 1'b1, 1'b0);
    gap(1);
    chk("R7 pulse one cycle", 1'b0, 1'b0);

    // R10: idle gaps inside the key keep progress
    acc(1,0,0,13'h0000); acc(1,0,0,13'h1555);
    gap(3);
    acc(1,0,0,13'h0AAA); acc(1,0,0,13'h1FFF); acc(1,0,0,13'h10F0);
    chk("R5 hiz low on fifth read", 1'b0, 1'b0);
    acc(1,0,0,13'h0F0E);
    chk("R10 idle gap", 1'b0, 1'b1);

    // R9: reset mid-key loses progress
    acc(1,0,0,13'h0000); acc(1,0,0,13'h1555); acc(1,0,0,13'h0AAA);
    @(negedge clk); acc_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #2;
    chk("R9 in reset", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    acc(1,0,0,13'h1FFF); acc(1,0,0,13'h10F0); acc(1,0,0,13'h0F0F);
    chk("R9 key lost", 1'b0, 1'b0);

    // R3: write on the sixth address
    acc(1,0,0,13'h0000); acc(1,0,0,13'h1555); acc(1,0,0,13'h0AAA);
    acc(1,0,0,13'h1FFF); acc(1,0,0,13'h10F0); acc(1,1,0,13'h0F0F);
    chk("R3 write at step six", 1'b0, 1'b0);

    gap(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule